// File: doc/BRIEF.md
# Configurable Register Field Storage

This block holds one field of a control/status register and decides, cycle by cycle, which of several requesters updates it. Software reaches the field through a write strobe with data, a read strobe, and a write-allow input whose polarity is set by a parameter. Hardware reaches it through a set input, a clear input, and a value load. The load has its own polarity parameter, and a per-bit select vector limits which bits it may change. A parameter chooses whether the select vector works as an enable or as a mask.

The field drives its stored value, AND/OR/XOR reductions of that value, and two single-cycle strobes. One strobe marks the cycle in which software samples the field. The other marks the cycle in which a software write modifies it. In single-pulse mode the field clears itself one cycle after any update, so a written one appears for exactly one cycle.

The reset input is asserted asynchronously and released synchronously. After release the field keeps its reset value until the internal reset has been released. That takes two clock edges.

Top module: `rf_field_core`

## Requirements
- R1: While reset is asserted, `field_q` equals `RESET_VAL`, and `rd_acc_pulse` and `wr_mod_pulse` are low even when the strobes are driven.
- R2: An allowed software write loads `sw_wr_data` into `field_q` on the next clock edge. It takes priority over every hardware request in the same cycle, and `wr_mod_pulse` is high during that write cycle.
- R3: A software write is allowed only when `sw_wr_allow` is active. Active means 1 when `SW_EN_LOW`=0 and 0 when `SW_EN_LOW`=1. A write that is not allowed leaves the field unchanged and keeps `wr_mod_pulse` low.
- R4: When there is no software write, `hw_set` drives every bit to 1 on the next edge. This holds even if `hw_clr` or a hardware load is active in the same cycle.
- R5: When there is no software write and no set, `hw_clr` drives every bit to 0 on the next edge, even if a hardware load is active.
- R6: A hardware load is active when `hw_load` is 1 (`HW_LD_LOW`=0) or 0 (`HW_LD_LOW`=1). If no higher-priority request is present, selected bits take `hw_data` on the next edge.
- R7: With `SEL_IS_MASK`=0, bit i of `hw_bitsel` set to 1 lets a load change bit i. With `SEL_IS_MASK`=1, bit i set to 1 holds bit i. Bits that are not selected keep their value.
- R8: With `PULSE_MODE`=1, any cycle without an update request clears the field on the next edge, so a written value stays visible for exactly one cycle.
- R9: `rd_acc_pulse` is high in exactly the cycles in which `sw_rd_stb` is high after reset.
- R10: `red_and`, `red_or` and `red_xor` give the AND, OR and XOR of the current `field_q`.
- R11: With `PULSE_MODE`=0 and no update request, `field_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_stb | input | 1 | Software write strobe |
| sw_wr_data | input | WIDTH | Software write data |
| sw_wr_allow | input | 1 | Software write permission, polarity set by SW_EN_LOW |
| sw_rd_stb | input | 1 | Software read strobe |
| hw_data | input | WIDTH | Hardware load value |
| hw_load | input | 1 | Hardware load request, polarity set by HW_LD_LOW |
| hw_set | input | 1 | Set all bits |
| hw_clr | input | 1 | Clear all bits |
| hw_bitsel | input | WIDTH | Per-bit enable or mask for hardware loads |
| field_q | output | WIDTH | Stored field value |
| rd_acc_pulse | output | 1 | Software read access strobe |
| wr_mod_pulse | output | 1 | Software modify strobe |
| red_and | output | 1 | AND reduction of field_q |
| red_or | output | 1 | OR reduction of field_q |
| red_xor | output | 1 | XOR reduction of field_q |

## Verification
A wrong priority choice, or a wrong bit-select decode, leaves a wrong value in the field register. That value shows up on `field_q` and on the reductions one clock edge after the offending request. The bench therefore compares every output after every edge against a behavioural model, and a single bad update cannot hide. A strobe that is mis-gated shows up in the same cycle as the request. Single-pulse mode and the inverted polarities run on a second instance alongside the first. A stuck self-clear appears one edge after the written cycle.

// File: rtl/rf_field_pkg.sv
package rf_field_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD = 3'd0,
    SRC_SW   = 3'd1,
    SRC_SET  = 3'd2,
    SRC_CLR  = 3'd3,
    SRC_LOAD = 3'd4,
    SRC_PCLR = 3'd5
  } rf_src_e;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rf_sw_port.sv
module rf_sw_port #(
  parameter bit SW_EN_LOW = 1'b0
) (
  input  logic core_rdy,
  input  logic sw_wr_stb,
  input  logic sw_wr_allow,
  input  logic sw_rd_stb,
  output logic sw_wr_ok,
  output logic rd_acc_pulse,
  output logic wr_mod_pulse
);
  logic allow_act;

  generate
    if (SW_EN_LOW) begin : g_allow_low
      assign allow_act = ~sw_wr_allow;
    end else begin : g_allow_high
      assign allow_act = sw_wr_allow;
    end
  endgenerate

  always_comb begin
    sw_wr_ok     = core_rdy & sw_wr_stb & allow_act;
    rd_acc_pulse = core_rdy & sw_rd_stb;
    wr_mod_pulse = sw_wr_ok;
  end
endmodule

// File: rtl/rf_hw_port.sv
module rf_hw_port #(
  parameter int unsigned WIDTH       = 8,
  parameter bit          HW_LD_LOW   = 1'b0,
  parameter bit          SEL_IS_MASK = 1'b0
) (
  input  logic             core_rdy,
  input  logic             hw_load,
  input  logic             hw_set,
  input  logic             hw_clr,
  input  logic [WIDTH-1:0] hw_bitsel,
  output logic             ld_ok,
  output logic             set_ok,
  output logic             clr_ok,
  output logic [WIDTH-1:0] upd_bits
);
  logic ld_act;

  generate
    if (HW_LD_LOW) begin : g_ld_low
      assign ld_act = ~hw_load;
    end else begin : g_ld_high
      assign ld_act = hw_load;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_sel
      if (SEL_IS_MASK) begin : g_mask
        assign upd_bits[b] = ~hw_bitsel[b];
      end else begin : g_enable
        assign upd_bits[b] = hw_bitsel[b];
      end
    end
  endgenerate

  always_comb begin
    ld_ok  = core_rdy & ld_act;
    set_ok = core_rdy & hw_set;
    clr_ok = core_rdy & hw_clr;
  end
endmodule

// File: rtl/rf_next_sel.sv
module rf_next_sel
  import rf_field_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter bit          PULSE_MODE = 1'b0
) (
  input  logic             core_rdy,
  input  logic [WIDTH-1:0] cur_q,
  input  logic             sw_wr_ok,
  input  logic [WIDTH-1:0] sw_wr_data,
  input  logic             set_ok,
  input  logic             clr_ok,
  input  logic             ld_ok,
  input  logic [WIDTH-1:0] hw_data,
  input  logic [WIDTH-1:0] upd_bits,
  output logic [WIDTH-1:0] nxt_q,
  output logic             upd_en,
  output rf_src_e          src
);
  localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZEROS = {WIDTH{1'b0}};

  logic [WIDTH-1:0] base_q;
  logic [WIDTH-1:0] merged_q;

  generate
    if (PULSE_MODE) begin : g_pulse_base
      assign base_q = ALL_ZEROS;
    end else begin : g_hold_base
      assign base_q = cur_q;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_merge
      assign merged_q[b] = upd_bits[b] ? hw_data[b] : base_q[b];
    end
  endgenerate

  always_comb begin
    if (!core_rdy) begin
      src = SRC_HOLD;
    end else if (sw_wr_ok) begin
      src = SRC_SW;
    end else if (set_ok) begin
      src = SRC_SET;
    end else if (clr_ok) begin
      src = SRC_CLR;
    end else if (ld_ok) begin
      src = SRC_LOAD;
    end else if (PULSE_MODE) begin
      src = SRC_PCLR;
    end else begin
      src = SRC_HOLD;
    end
  end

  always_comb begin
    upd_en = 1'b1;
    unique case (src)
      SRC_SW:   nxt_q = sw_wr_data;
      SRC_SET:  nxt_q = ALL_ONES;
      SRC_CLR:  nxt_q = ALL_ZEROS;
      SRC_LOAD: nxt_q = merged_q;
      SRC_PCLR: nxt_q = ALL_ZEROS;
      default: begin
        nxt_q  = cur_q;
        upd_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rf_field_core.sv
module rf_field_core
  import rf_field_pkg::*;
#(
  parameter int unsigned      WIDTH       = 8,
  parameter logic [WIDTH-1:0] RESET_VAL   = 8'hA5,
  parameter bit               PULSE_MODE  = 1'b0,
  parameter bit               SW_EN_LOW   = 1'b0,
  parameter bit               HW_LD_LOW   = 1'b0,
  parameter bit               SEL_IS_MASK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_stb,
  input  logic [WIDTH-1:0] sw_wr_data,
  input  logic             sw_wr_allow,
  input  logic             sw_rd_stb,
  input  logic [WIDTH-1:0] hw_data,
  input  logic             hw_load,
  input  logic             hw_set,
  input  logic             hw_clr,
  input  logic [WIDTH-1:0] hw_bitsel,
  output logic [WIDTH-1:0] field_q,
  output logic             rd_acc_pulse,
  output logic             wr_mod_pulse,
  output logic             red_and,
  output logic             red_or,
  output logic             red_xor
);
  logic             core_rdy;
  logic             sw_wr_ok;
  logic             ld_ok;
  logic             set_ok;
  logic             clr_ok;
  logic [WIDTH-1:0] upd_bits;
  logic [WIDTH-1:0] nxt_q;
  logic             upd_en;
  rf_src_e          src;
  logic [WIDTH-1:0] store_q;

  rf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rdy)
  );

  rf_sw_port #(
    .SW_EN_LOW (SW_EN_LOW)
  ) u_sw_port (
    .core_rdy     (core_rdy),
    .sw_wr_stb    (sw_wr_stb),
    .sw_wr_allow  (sw_wr_allow),
    .sw_rd_stb    (sw_rd_stb),
    .sw_wr_ok     (sw_wr_ok),
    .rd_acc_pulse (rd_acc_pulse),
    .wr_mod_pulse (wr_mod_pulse)
  );

  rf_hw_port #(
    .WIDTH       (WIDTH),
    .HW_LD_LOW   (HW_LD_LOW),
    .SEL_IS_MASK (SEL_IS_MASK)
  ) u_hw_port (
    .core_rdy  (core_rdy),
    .hw_load   (hw_load),
    .hw_set    (hw_set),
    .hw_clr    (hw_clr),
    .hw_bitsel (hw_bitsel),
    .ld_ok     (ld_ok),
    .set_ok    (set_ok),
    .clr_ok    (clr_ok),
    .upd_bits  (upd_bits)
  );

  rf_next_sel #(
    .WIDTH      (WIDTH),
    .PULSE_MODE (PULSE_MODE)
  ) u_next_sel (
    .core_rdy   (core_rdy),
    .cur_q      (store_q),
    .sw_wr_ok   (sw_wr_ok),
    .sw_wr_data (sw_wr_data),
    .set_ok     (set_ok),
    .clr_ok     (clr_ok),
    .ld_ok      (ld_ok),
    .hw_data    (hw_data),
    .upd_bits   (upd_bits),
    .nxt_q      (nxt_q),
    .upd_en     (upd_en),
    .src        (src)
  );

  always_ff @(posedge clk or negedge core_rdy) begin
    if (!core_rdy) begin
      store_q <= RESET_VAL;
    end else if (upd_en) begin
      store_q <= nxt_q;
    end
  end

  always_comb begin
    field_q = store_q;
    red_and = &store_q;
    red_or  = |store_q;
    red_xor = ^store_q;
  end
endmodule

// File: rtl/rf_field_chk.sv
module rf_field_chk #(
  parameter int unsigned WIDTH       = 8,
  parameter bit          PULSE_MODE  = 1'b0,
  parameter bit          HW_LD_LOW   = 1'b0,
  parameter bit          SEL_IS_MASK = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_rdy,
  input logic [WIDTH-1:0] sw_wr_data,
  input logic [WIDTH-1:0] hw_data,
  input logic             hw_load,
  input logic             hw_set,
  input logic             hw_clr,
  input logic [WIDTH-1:0] hw_bitsel,
  input logic [WIDTH-1:0] field_q,
  input logic             rd_acc_pulse,
  input logic             wr_mod_pulse
);
  logic             ld_on;
  logic [WIDTH-1:0] upd;
  logic             idle;

  assign ld_on = HW_LD_LOW ? ~hw_load : hw_load;
  assign upd   = SEL_IS_MASK ? ~hw_bitsel : hw_bitsel;
  assign idle  = !wr_mod_pulse && !hw_set && !hw_clr && !ld_on;

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      assert_quiet_reset_R1: assert (!rd_acc_pulse && !wr_mod_pulse)
        else $error("strobe active in reset");
    end
  end

  assert_sw_wins_R2: assert property (@(posedge clk) disable iff (!core_rdy)
    wr_mod_pulse |=> field_q == $past(sw_wr_data));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!core_rdy)
    (hw_set && !wr_mod_pulse) |=> field_q == {WIDTH{1'b1}});

  assert_clr_R5: assert property (@(posedge clk) disable iff (!core_rdy)
    (hw_clr && !hw_set && !wr_mod_pulse) |=> field_q == {WIDTH{1'b0}});

  assert_load_R6: assert property (@(posedge clk) disable iff (!core_rdy)
    (ld_on && !hw_set && !hw_clr && !wr_mod_pulse)
      |=> (field_q & $past(upd)) == ($past(hw_data) & $past(upd)));

  generate
    if (PULSE_MODE) begin : g_pulse_chk
      assert_self_clear_R8: assert property (@(posedge clk) disable iff (!core_rdy)
        idle |=> field_q == {WIDTH{1'b0}});
    end else begin : g_hold_chk
      assert_bits_held_R7: assert property (@(posedge clk) disable iff (!core_rdy)
        (ld_on && !hw_set && !hw_clr && !wr_mod_pulse)
          |=> ((field_q ^ $past(field_q)) & ~$past(upd)) == {WIDTH{1'b0}});
      assert_hold_R11: assert property (@(posedge clk) disable iff (!core_rdy)
        idle |=> $stable(field_q));
    end
  endgenerate
endmodule

bind rf_field_core rf_field_chk #(
  .WIDTH       (WIDTH),
  .PULSE_MODE  (PULSE_MODE),
  .HW_LD_LOW   (HW_LD_LOW),
  .SEL_IS_MASK (SEL_IS_MASK)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_rdy     (core_rdy),
  .sw_wr_data   (sw_wr_data),
  .hw_data      (hw_data),
  .hw_load      (hw_load),
  .hw_set       (hw_set),
  .hw_clr       (hw_clr),
  .hw_bitsel    (hw_bitsel),
  .field_q      (field_q),
  .rd_acc_pulse (rd_acc_pulse),
  .wr_mod_pulse (wr_mod_pulse)
);

// File: tb/rf_field_core_tb_top.sv
`timescale 1ns/1ps
module rf_field_core_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic       wr, allow, rd, set, clr, ld;
  logic [7:0] wdat, hdat, en;

  logic [7:0] q_m, q_p;
  logic acc_m, mod_m, and_m, or_m, xor_m;
  logic acc_p, mod_p, and_p, or_p, xor_p;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [7:0] exp_m, exp_p;

  // main instance: hold mode, active-high controls, enable select
  rf_field_core #(.WIDTH(8), .RESET_VAL(8'hA5)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_stb(wr), .sw_wr_data(wdat),
    .sw_wr_allow(allow), .sw_rd_stb(rd), .hw_data(hdat), .hw_load(ld),
    .hw_set(set), .hw_clr(clr), .hw_bitsel(en), .field_q(q_m),
    .rd_acc_pulse(acc_m), .wr_mod_pulse(mod_m), .red_and(and_m),
    .red_or(or_m), .red_xor(xor_m));

  // second instance: pulse mode, active-low controls, mask select
  rf_field_core #(.WIDTH(8), .RESET_VAL(8'h3C), .PULSE_MODE(1'b1),
                  .SW_EN_LOW(1'b1), .HW_LD_LOW(1'b1), .SEL_IS_MASK(1'b1)) dut_pulse_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_stb(wr), .sw_wr_data(wdat),
    .sw_wr_allow(~allow), .sw_rd_stb(rd), .hw_data(hdat), .hw_load(~ld),
    .hw_set(set), .hw_clr(clr), .hw_bitsel(~en), .field_q(q_p),
    .rd_acc_pulse(acc_p), .wr_mod_pulse(mod_p), .red_and(and_p),
    .red_or(or_p), .red_xor(xor_p));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] cur, input bit pulse,
      input logic w, input logic a, input logic [7:0] wd, input logic s,
      input logic c, input logic l, input logic [7:0] hd, input logic [7:0] e);
    logic [7:0] r;
    if (w && a) return wd;
    if (s) return 8'hFF;
    if (c) return 8'h00;
    r = pulse ? 8'h00 : cur;
    if (l) begin
      for (int i = 0; i < 8; i++) if (e[i]) r[i] = hd[i];
    end
    return r;
  endfunction

  task automatic cyc(input string tag, input logic w, input logic a,
      input logic [7:0] wd, input logic r, input logic s, input logic c,
      input logic l, input logic [7:0] hd, input logic [7:0] e);
    @(negedge clk);
    wr = w; allow = a; wdat = wd; rd = r; set = s; clr = c; ld = l; hdat = hd; en = e;
    #2;
    chk("R2 mod strobe main", mod_m, w & a);
    chk("R3 mod strobe pulse", mod_p, w & a);
    chk("R9 acc strobe main", acc_m, r);
    chk("R9 acc strobe pulse", acc_p, r);
    exp_m = model(exp_m, 1'b0, w, a, wd, s, c, l, hd, e);
    exp_p = model(exp_p, 1'b1, w, a, wd, s, c, l, hd, e);
    @(posedge clk);
    #2;
    chk({tag, " main"}, q_m, exp_m);
    chk({tag, " pulse"}, q_p, exp_p);
    chk("R10 and", {and_m, and_p}, {&exp_m, &exp_p});
    chk("R10 or",  {or_m,  or_p},  {|exp_m, |exp_p});
    chk("R10 xor", {xor_m, xor_p}, {^exp_m, ^exp_p});
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 1, 8'h00, 0, 0, 0, 0, 8'h00, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;
    wr = 1; allow = 1; wdat = 8'h11; rd = 1; set = 0; clr = 0; ld = 0; hdat = 0; en = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset value and quiet strobes while reset is held
    chk("R1 reset value main", q_m, 8'hA5);
    chk("R1 reset value pulse", q_p, 8'h3C);
    chk("R1 strobes quiet", {acc_m, mod_m, acc_p, mod_p}, 4'b0000);
    @(negedge clk);
    wr = 0; rd = 0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    exp_m = 8'hA5;
    exp_p = 8'h00;
    chk("R11 held after release", q_m, 8'hA5);
    chk("R8 cleared after release", q_p, 8'h00);

    idle("R11 idle");
    idle("R11 idle");
    cyc("R2 write", 1, 1, 8'h5A, 0, 0, 0, 0, 8'h00, 8'h00);
    cyc("R3 blocked write", 1, 0, 8'hFF, 0, 0, 0, 0, 8'h00, 8'h00);
    cyc("R9 read", 0, 1, 8'h00, 1, 0, 0, 0, 8'h00, 8'h00);
    cyc("R4 set", 0, 1, 8'h00, 0, 1, 0, 0, 8'h00, 8'h00);
    cyc("R5 clr", 0, 1, 8'h00, 0, 0, 1, 0, 8'h00, 8'h00);
    cyc("R4 set beats clr", 0, 1, 8'h00, 0, 1, 1, 1, 8'h12, 8'hFF);
    cyc("R5 clr beats load", 0, 1, 8'h00, 0, 0, 1, 1, 8'h77, 8'hFF);
    cyc("R6 full load", 0, 1, 8'h00, 0, 0, 0, 1, 8'h33, 8'hFF);
    cyc("R7 partial load", 0, 1, 8'h00, 0, 0, 0, 1, 8'hCC, 8'h0F);
    cyc("R6 no load", 0, 1, 8'h00, 0, 0, 0, 0, 8'h99, 8'hFF);
    cyc("R7 all held", 0, 1, 8'h00, 0, 0, 0, 1, 8'h00, 8'h00);
    cyc("R2 sw beats set", 1, 1, 8'h81, 1, 1, 1, 1, 8'h44, 8'hFF);
    idle("R8 self clear");
    idle("R8 stays clear");
    cyc("R10 ones", 1, 1, 8'hFF, 0, 0, 0, 0, 8'h00, 8'h00);
    cyc("R10 single", 1, 1, 8'h01, 0, 0, 0, 0, 8'h00, 8'h00);
    cyc("R10 zeros", 1, 1, 8'h00, 0, 0, 0, 0, 8'h00, 8'h00);

    lf = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc("R6 mixed", lf[0] & lf[5], lf[1], lf[15:8], lf[2], lf[3] & lf[6],
          lf[4] & lf[7], lf[9], lf[7:0] ^ 8'h5C, lf[13:6]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule